// File: doc/BRIEF.md
# Single-Bus Multicycle PC-Relative Load Processor

This block is a multicycle processor slice that executes one instruction: a load of a 32-bit word from data memory at an address relative to the program counter. All register-to-register traffic inside the slice moves over one shared internal write bus. A Moore controller sequences the fetch, decode with PC increment, address formation, data read and register writeback steps. Each step's controls depend only on the current state.

The effective address is formed without a dedicated adder. The incremented PC and the sign-extended offset are each carried over the write bus into one of two scratchpad entries of the register file. Both entries are then read into the ALU input registers and added, and the sum travels back over the bus into the memory address register. This path takes exactly five cycles. Instruction and data memories are separate, and each answers a request with a ready strobe after any number of wait cycles. Every completed load is shown on a retirement port, which carries the destination index and the value written. An instruction that fails decode stops the slice until reset.

Top module: `pcl_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the PC equals RESET_PC, the instruction request is high with `imem_addr` equal to RESET_PC, and `dmem_rd`, `ret_valid` and `halted` are low.
- R2: In the fetch state `imem_req` is high and `imem_addr` equals the PC. The slice stays in fetch until a cycle with `imem_ready` high, and the instruction register captures `imem_rdata` only in that cycle.
- R3: The cycle after fetch completes is a single decode cycle, in which the PC advances by 4. The following fetch uses the advanced PC.
- R4: Instruction fields: opcode in bits [31:26], destination register in bits [25:21], reserved bits [20:16], and a 16-bit two's-complement offset in bits [15:0] that is sign-extended to 32 bits. An instruction is a load only if its opcode equals LOAD_OP (default 6'h23) and its reserved bits are all zero.
- R5: For a load, `dmem_rd` first rises exactly six cycles after the decode cycle, which leaves five address-formation cycles.
- R6: In every state at most one source drives the internal write bus.
- R7: While `dmem_rd` is high, `dmem_addr` equals the advanced PC plus the sign-extended offset, modulo 2^32, and stays constant. The slice waits until a cycle with `dmem_ready` high and captures `dmem_rdata` in that cycle.
- R8: In the cycle after the data read completes, `ret_valid` is high for exactly one cycle, with `ret_rd` equal to the destination field and `ret_data` equal to the word read. The register is written, and fetch of the next instruction starts in the following cycle.
- R9: After a decode that finds no load, `halted` stays high and `imem_req`, `dmem_rd` and `ret_valid` stay low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | 32 | Instruction address (the PC) |
| imem_ready | input | 1 | Instruction word valid this cycle |
| imem_rdata | input | 32 | Instruction word |
| dmem_rd | output | 1 | Data read request |
| dmem_addr | output | 32 | Data address (memory address register) |
| dmem_ready | input | 1 | Data word valid this cycle |
| dmem_rdata | input | 32 | Data word |
| ret_valid | output | 1 | A load writes its destination this cycle |
| ret_rd | output | 5 | Destination register index of the load |
| ret_data | output | 32 | Value written to the destination |
| halted | output | 1 | Slice stopped on an undecodable instruction |

## Verification
The assertions check on every cycle that the write bus has at most one driver and that fetch and data read hold while ready is low. They also check that address formation takes five cycles, that writeback leads straight back to fetch, that the halt state is never left, that the data address is stable during a read, and that every decode moves the PC by exactly 4. The effective address itself, the sign extension of negative and extreme offsets, the returned data and destination index, and the effect of a nonzero reserved field can only be shown by the bench's scenarios. There, a cycle-accurate reference model runs against memories with random wait cycles and compares every output on every clock.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  localparam int XLEN    = 32;
  localparam int OP_MSB  = 31;
  localparam int OP_LSB  = 26;
  localparam int RD_MSB  = 25;
  localparam int RD_LSB  = 21;
  localparam int RSV_MSB = 20;
  localparam int RSV_LSB = 16;
  localparam int OFF_W   = 16;
  localparam int OP_W    = OP_MSB - OP_LSB + 1;
  localparam int RD_W    = RD_MSB - RD_LSB + 1;
  localparam int RSV_W   = RSV_MSB - RSV_LSB + 1;

  // write-bus source positions
  localparam int DRV_PC  = 0;
  localparam int DRV_OFF = 1;
  localparam int DRV_ALU = 2;
  localparam int DRV_MDR = 3;
  localparam int NDRV    = 4;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_AC_PC,
    ST_AC_OFF,
    ST_AC_RD,
    ST_AC_ADD,
    ST_AC_MAR,
    ST_DFETCH,
    ST_WBACK,
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    WSEL_SP0,
    WSEL_SP1,
    WSEL_RD
  } wsel_e;

  typedef struct packed {
    logic            imem_req;
    logic            pc_ld;
    logic [NDRV-1:0] drv;
    logic            rf_we;
    wsel_e           wsel;
    logic            alu_in_ld;
    logic            alu_out_ld;
    logic            mar_ld;
    logic            dmem_rd;
    logic            ret;
    logic            halt;
  } ctl_t;

endpackage

// File: rtl/pcl_ctrl.sv
module pcl_ctrl
  import pcl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic imem_ready,
  input  logic dmem_ready,
  input  logic op_ok,
  output ctl_t ctl
);

  state_e state_q;
  state_e state_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  if (imem_ready) state_d = ST_DECODE;
      ST_DECODE: state_d = op_ok ? ST_AC_PC : ST_HALT;
      ST_AC_PC:  state_d = ST_AC_OFF;
      ST_AC_OFF: state_d = ST_AC_RD;
      ST_AC_RD:  state_d = ST_AC_ADD;
      ST_AC_ADD: state_d = ST_AC_MAR;
      ST_AC_MAR: state_d = ST_DFETCH;
      ST_DFETCH: if (dmem_ready) state_d = ST_WBACK;
      ST_WBACK:  state_d = ST_FETCH;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  // Moore outputs: a function of the state alone
  always_comb begin
    ctl = '0;
    unique case (state_q)
      ST_FETCH:  ctl.imem_req = 1'b1;
      ST_DECODE: ctl.pc_ld    = 1'b1;
      ST_AC_PC: begin
        ctl.drv[DRV_PC] = 1'b1;
        ctl.rf_we       = 1'b1;
        ctl.wsel        = WSEL_SP0;
      end
      ST_AC_OFF: begin
        ctl.drv[DRV_OFF] = 1'b1;
        ctl.rf_we        = 1'b1;
        ctl.wsel         = WSEL_SP1;
      end
      ST_AC_RD:  ctl.alu_in_ld  = 1'b1;
      ST_AC_ADD: ctl.alu_out_ld = 1'b1;
      ST_AC_MAR: begin
        ctl.drv[DRV_ALU] = 1'b1;
        ctl.mar_ld       = 1'b1;
      end
      ST_DFETCH: ctl.dmem_rd = 1'b1;
      ST_WBACK: begin
        ctl.drv[DRV_MDR] = 1'b1;
        ctl.rf_we        = 1'b1;
        ctl.wsel         = WSEL_RD;
        ctl.ret          = 1'b1;
      end
      ST_HALT:   ctl.halt = 1'b1;
      default:   ctl.halt = 1'b1;
    endcase
  end

  AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl.drv)); // R6
  AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && !imem_ready) |=> state_q == ST_FETCH); // R2
  AST_DATA_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DFETCH && !dmem_ready) |=> state_q == ST_DFETCH); // R7
  AST_ADDR_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DFETCH && $past(state_q) == ST_AC_MAR) |-> $past(state_q, 6) == ST_DECODE); // R5
  AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WBACK |=> state_q == ST_FETCH); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HALT |=> (state_q == ST_HALT && !ctl.imem_req && !ctl.dmem_rd)); // R9

endmodule

// File: rtl/pcl_regfile.sv
module pcl_regfile #(
  parameter int W       = 32,
  parameter int ENTRIES = 34,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic         en;
    logic [W-1:0] r;
    assign en = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r <= '0;
      else if (en) r <= wdata;
    end
    assign q[i] = r;
  end

  assign rdata_a = q[raddr_a];
  assign rdata_b = q[raddr_b];

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(waddr) < ENTRIES); // R8

endmodule

// File: rtl/pcl_alu.sv
module pcl_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_ld,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         out_ld,
  output logic [W-1:0] y
);

  logic [W-1:0] a_q, b_q, y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (in_ld) begin
      a_q <= a;
      b_q <= b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y_q <= '0;
    else if (out_ld) y_q <= a_q + b_q;
  end

  assign y = y_q;

endmodule

// File: rtl/pcl_wbus.sv
module pcl_wbus #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic [N-1:0][W-1:0] src,
  input  logic [N-1:0]        sel,
  output logic [W-1:0]        y
);

  logic [N-1:0][W-1:0] masked;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign masked[i] = src[i] & {W{sel[i]}};
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < N; i++) y = y | masked[i];
  end

endmodule

// File: rtl/pcl_core.sv
module pcl_core
  import pcl_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [OP_W-1:0] LOAD_OP  = 6'h23
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            imem_req,
  output logic [XLEN-1:0] imem_addr,
  input  logic            imem_ready,
  input  logic [XLEN-1:0] imem_rdata,
  output logic            dmem_rd,
  output logic [XLEN-1:0] dmem_addr,
  input  logic            dmem_ready,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            ret_valid,
  output logic [RD_W-1:0] ret_rd,
  output logic [XLEN-1:0] ret_data,
  output logic            halted
);

  localparam int ARCH_REGS = 2 ** RD_W;
  localparam int RF_N      = ARCH_REGS + 2;
  localparam int IDXW      = $clog2(RF_N);
  localparam logic [IDXW-1:0] SP0_IDX = IDXW'(ARCH_REGS);
  localparam logic [IDXW-1:0] SP1_IDX = IDXW'(ARCH_REGS + 1);

  ctl_t ctl;

  logic [XLEN-1:0] pc_q, pc_inc;
  logic [XLEN-1:0] ir_q, mar_q, mdr_q;
  logic [XLEN-1:0] wbus, off_ext, alu_y;
  logic [XLEN-1:0] rf_a, rf_b;
  logic [IDXW-1:0] rf_waddr;
  logic            ir_ld, mdr_ld, op_ok;
  logic [NDRV-1:0][XLEN-1:0] bus_src;

  logic [OP_W-1:0]  ir_op;
  logic [RD_W-1:0]  ir_rd;
  logic [RSV_W-1:0] ir_rsv;
  logic [OFF_W-1:0] ir_off;

  assign ir_op  = ir_q[OP_MSB:OP_LSB];
  assign ir_rd  = ir_q[RD_MSB:RD_LSB];
  assign ir_rsv = ir_q[RSV_MSB:RSV_LSB];
  assign ir_off = ir_q[OFF_W-1:0];

  assign op_ok   = (ir_op == LOAD_OP) && (ir_rsv == '0);
  assign off_ext = {{(XLEN-OFF_W){ir_off[OFF_W-1]}}, ir_off};
  assign pc_inc  = pc_q + XLEN'(4);
  assign ir_ld   = ctl.imem_req & imem_ready;
  assign mdr_ld  = ctl.dmem_rd & dmem_ready;

  pcl_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_ready (imem_ready),
    .dmem_ready (dmem_ready),
    .op_ok      (op_ok),
    .ctl        (ctl)
  );

  // program counter with its own incrementer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc_q <= RESET_PC;
    else if (ctl.pc_ld) pc_q <= pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_ld) ir_q <= imem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mar_q <= '0;
    else if (ctl.mar_ld) mar_q <= wbus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mdr_q <= '0;
    else if (mdr_ld) mdr_q <= dmem_rdata;
  end

  // shared write bus
  assign bus_src[DRV_PC]  = pc_q;
  assign bus_src[DRV_OFF] = off_ext;
  assign bus_src[DRV_ALU] = alu_y;
  assign bus_src[DRV_MDR] = mdr_q;

  pcl_wbus #(.W(XLEN), .N(NDRV)) u_wbus (
    .src (bus_src),
    .sel (ctl.drv),
    .y   (wbus)
  );

  always_comb begin
    unique case (ctl.wsel)
      WSEL_SP0: rf_waddr = SP0_IDX;
      WSEL_SP1: rf_waddr = SP1_IDX;
      default:  rf_waddr = IDXW'(ir_rd);
    endcase
  end

  pcl_regfile #(.W(XLEN), .ENTRIES(RF_N)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl.rf_we),
    .waddr   (rf_waddr),
    .wdata   (wbus),
    .raddr_a (SP0_IDX),
    .raddr_b (SP1_IDX),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  pcl_alu #(.W(XLEN)) u_alu (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_ld  (ctl.alu_in_ld),
    .a      (rf_a),
    .b      (rf_b),
    .out_ld (ctl.alu_out_ld),
    .y      (alu_y)
  );

  assign imem_req  = ctl.imem_req;
  assign imem_addr = pc_q;
  assign dmem_rd   = ctl.dmem_rd;
  assign dmem_addr = mar_q;
  assign ret_valid = ctl.ret;
  assign ret_rd    = ir_rd;
  assign ret_data  = wbus;
  assign halted    = ctl.halt;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_ld |=> imem_addr == $past(imem_addr) + XLEN'(4)); // R3
  AST_IR_ONLY_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_req && imem_ready) |=> $stable(ir_q)); // R2
  AST_DADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_rd && $past(dmem_rd)) |-> $stable(dmem_addr)); // R7
  AST_RET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !ret_valid && imem_req); // R8

endmodule

// File: tb/pcl_core_tb.sv
module pcl_core_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        imem_req, imem_ready;
  logic [31:0] imem_addr, imem_rdata;
  logic        dmem_rd, dmem_ready;
  logic [31:0] dmem_addr, dmem_rdata;
  logic        ret_valid, halted;
  logic [4:0]  ret_rd;
  logic [31:0] ret_data;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;

  always #10 clk = ~clk;

  pcl_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_req   (imem_req),
    .imem_addr  (imem_addr),
    .imem_ready (imem_ready),
    .imem_rdata (imem_rdata),
    .dmem_rd    (dmem_rd),
    .dmem_addr  (dmem_addr),
    .dmem_ready (dmem_ready),
    .dmem_rdata (dmem_rdata),
    .ret_valid  (ret_valid),
    .ret_rd     (ret_rd),
    .ret_data   (ret_data),
    .halted     (halted)
  );

  logic [31:0] prog [64];

  // reference model state
  int          ph;
  int          nret;
  int          icnt, itgt, dcnt, dtgt;
  logic [31:0] mpc, mir, mmar, mmdr;

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rd,
                                      input logic [4:0] rsv, input logic [15:0] off);
    return {op, rd, rsv, off};
  endfunction

  function automatic logic [31:0] dval(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h3C5A_0F96;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare, then drive memories, then advance the model: once per negedge
  always @(negedge clk) begin
    if (run) begin
      chk(imem_req == (ph == 0), "R2 fetch request", 32'(imem_req), 32'(ph == 0));
      if (ph == 0) chk(imem_addr == mpc, "R2 R3 fetch address", imem_addr, mpc);
      chk(dmem_rd == (ph == 7), "R5 data request timing", 32'(dmem_rd), 32'(ph == 7));
      if (ph == 7) chk(dmem_addr == mmar, "R7 R4 effective address", dmem_addr, mmar);
      chk(ret_valid == (ph == 8), "R8 writeback strobe", 32'(ret_valid), 32'(ph == 8));
      if (ph == 8) begin
        chk(ret_rd == mir[25:21], "R8 destination index", 32'(ret_rd), 32'(mir[25:21]));
        chk(ret_data == mmdr, "R8 R6 written value", ret_data, mmdr);
        nret++;
      end
      chk(halted == (ph == 9), "R9 R3 halt state", 32'(halted), 32'(ph == 9));

      imem_ready = 1'b0;
      if (imem_req) begin
        if (icnt >= itgt) begin
          imem_ready = 1'b1;
          imem_rdata = prog[imem_addr[7:2]];
          icnt = 0;
          itgt = $urandom_range(3, 0);
        end else icnt++;
      end
      dmem_ready = 1'b0;
      if (dmem_rd) begin
        if (dcnt >= dtgt) begin
          dmem_ready = 1'b1;
          dmem_rdata = dval(dmem_addr);
          dcnt = 0;
          dtgt = $urandom_range(3, 0);
        end else dcnt++;
      end

      case (ph)
        0: if (imem_ready) begin mir = imem_rdata; ph = 1; end
        1: begin
          mpc = mpc + 32'd4;
          ph = (mir[31:26] == 6'h23 && mir[20:16] == 5'd0) ? 2 : 9;
        end
        2, 3, 4, 5: ph++;
        6: begin mmar = mpc + {{16{mir[15]}}, mir[15:0]}; ph = 7; end
        7: if (dmem_ready) begin mmdr = dmem_rdata; ph = 8; end
        8: ph = 0;
        default: ph = 9;
      endcase
    end
  end

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0;
    rst_n = 1'b0;
    imem_ready = 1'b0;
    dmem_ready = 1'b0;
    imem_rdata = '0;
    dmem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(imem_req == 1'b1, "R1 reset fetch request", 32'(imem_req), 32'd1);
    chk(imem_addr == 32'd0, "R1 reset PC", imem_addr, 32'd0);
    chk(!dmem_rd && !ret_valid && !halted, "R1 reset idle outputs",
        {29'd0, dmem_rd, ret_valid, halted}, 32'd0);
    ph = 0; nret = 0; mpc = 32'd0; mir = '0; mmar = '0; mmdr = '0;
    icnt = 0; itgt = 0; dcnt = 0; dtgt = 3;
    rst_n = 1'b1;
    run = 1'b1;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    imem_ready = 1'b0;
    dmem_ready = 1'b0;
    imem_rdata = '0;
    dmem_rdata = '0;
    for (int i = 0; i < 64; i++) prog[i] = '0;

    // program 1: offsets of every sign and both extremes, then an illegal opcode
    prog[0] = enc(6'h23, 5'd3,  5'd0, 16'h0010);
    prog[1] = enc(6'h23, 5'd0,  5'd0, 16'hFFF0);
    prog[2] = enc(6'h23, 5'd31, 5'd0, 16'h7FFF);
    prog[3] = enc(6'h23, 5'd7,  5'd0, 16'h8000);
    prog[4] = enc(6'h23, 5'd12, 5'd0, 16'h0000);
    prog[5] = enc(6'h23, 5'd12, 5'd0, 16'hFFFC);
    prog[6] = enc(6'h23, 5'd5,  5'd0, 16'h0100);
    prog[7] = enc(6'h00, 5'd1,  5'd0, 16'h0004);
    do_reset();
    wait_halt();
    chk(nret == 7, "R8 loads retired in program 1", 32'(nret), 32'd7);
    chk(halted == 1'b1, "R9 stop on unknown opcode", 32'(halted), 32'd1);
    chk(!imem_req && !dmem_rd, "R9 no requests while stopped",
        {30'd0, imem_req, dmem_rd}, 32'd0);

    // program 2: reset while stopped, then a load-op with a reserved bit set
    prog[0] = enc(6'h23, 5'd9, 5'd0,  16'hFF00);
    prog[1] = enc(6'h23, 5'd4, 5'd1,  16'h0008);
    do_reset();
    wait_halt();
    chk(nret == 1, "R4 reserved bits block the load", 32'(nret), 32'd1);
    chk(halted == 1'b1, "R4 reserved bits stop the slice", 32'(halted), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule